// File: doc/BRIEF.md
# Push-Button Self-Test Sequencer

This block runs the user self-test of a photoelectric smoke sensing front end. A push-button input with a pulldown is synchronized and filtered. While the button is held, the block asks the analog side for boosted amplifier gain and switches the emitter pulse request to a fast test interval. It then watches the per-pulse smoke comparator result. A run of consecutive simulated-smoke results passes the test. The block then drives a passing alarm code, enables the horn pattern and drives the interconnect line. A run of consecutive misses fails the test: the block reports only a failing code and keeps the horn and interconnect off.

When the button is let go, the boosted gain stays on until the next oscillator tick. The block then counts a fixed number of further emitter pulses and returns to standby. The release edge also produces a one-cycle clear for the latched-alarm memory, and a one-cycle restart for the hush timer when the hush strap is set. Both pulse intervals are given in oscillator ticks, and the oscillator arrives as a one-cycle tick strobe.

Top module: `ptest_seq`

## Requirements
- R1: After reset, gain_boost_o, horn_en_o, io_en_o, hush_restart_o and latch_clear_o are low and alarm_code_o is 000.
- R2: A test starts only after test_i has been seen high on two consecutive clock samples after synchronization; a one-clock high pulse on test_i has no effect.
- R3: gain_boost_o is high while the button is held.
- R4: In standby, ired_req_o pulses once every STBY_IVL oscillator ticks. From press until standby returns, it pulses once every TEST_IVL ticks, and each pulse follows a tick.
- R5: PASS_RUN consecutive smoke results (smoke_i=1 with smoke_valid_i) during a held test set alarm_code_o to 011 and raise horn_en_o and io_en_o.
- R6: FAIL_RUN consecutive no-smoke results set alarm_code_o to 100 while horn_en_o and io_en_o stay low.
- R7: A smoke result clears the run of misses and a miss clears the run of smoke results, so interleaved patterns with no run of three leave alarm_code_o at 000.
- R8: After the release edge, gain_boost_o falls on exactly the first oscillator tick that follows.
- R9: After gain drops, the block returns to standby (alarm_code_o 000, horn and interconnect off) in the cycle after the EXIT_PULSES-th ired_req_o pulse, and holds the verdict outputs until then.
- R10: Each release produces exactly one one-cycle latch_clear_o pulse.
- R11: hush_restart_o pulses together with latch_clear_o only when hush_en_i is high, and never otherwise.
- R12: Once a verdict is reached, further comparator results during the same press do not change alarm_code_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| osc_tick_i | input | 1 | One-cycle strobe per oscillator period |
| test_i | input | 1 | Raw push-to-test button level |
| hush_en_i | input | 1 | Strap enabling the hush timer restart |
| smoke_valid_i | input | 1 | Comparator result valid for the last emitter pulse |
| smoke_i | input | 1 | Comparator result, 1 = smoke |
| gain_boost_o | output | 1 | Select boosted amplifier gain |
| ired_req_o | output | 1 | One-cycle emitter pulse request |
| alarm_code_o | output | 3 | Alarm type: 000 none, 011 test pass, 100 test fail |
| horn_en_o | output | 1 | Enable horn pattern |
| io_en_o | output | 1 | Drive interconnect line |
| hush_restart_o | output | 1 | One-cycle hush timer restart |
| latch_clear_o | output | 1 | One-cycle clear of the latched-alarm memory |

## Verification
On every cycle, the assertions check the local rules. The horn only sounds with a passing code. A failing code keeps horn and interconnect silent. Emitter requests and the gain drop follow an oscillator tick. Clear and hush pulses last one cycle and are gated by the strap. A reached verdict never flips, and the code clears at standby only after a pulse. Other properties span many cycles and only the bench scenarios can show them. These are the exact pulse intervals and the two-sample filter against glitches. They also include the run counting over whole result patterns, including interleaved and random ones, and the count of three exit pulses before standby.

// File: rtl/ptest_pkg.sv
package ptest_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HELD,
    ST_REL_GAIN,
    ST_REL_CNT
  } seq_state_e;

  typedef enum logic [1:0] {
    VD_NONE,
    VD_PASS,
    VD_FAIL
  } verdict_e;

  localparam logic [2:0] CODE_NONE = 3'b000;
  localparam logic [2:0] CODE_PASS = 3'b011;
  localparam logic [2:0] CODE_FAIL = 3'b100;

endpackage

// File: rtl/ptest_sync.sv
module ptest_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] sh_q;
  logic              lvl_q;
  logic              lvl_d1_q;

  // level only moves when the last two stages agree: one-sample glitches drop out
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q     <= '0;
      lvl_q    <= 1'b0;
      lvl_d1_q <= 1'b0;
    end else begin
      sh_q     <= {sh_q[STAGES-2:0], async_i};
      if (sh_q[STAGES-1] == sh_q[STAGES-2]) lvl_q <= sh_q[STAGES-1];
      lvl_d1_q <= lvl_q;
    end
  end

  assign level_o = lvl_q;
  assign rise_o  = lvl_q & ~lvl_d1_q;
  assign fall_o  = ~lvl_q & lvl_d1_q;

endmodule

// File: rtl/ptest_pulse_timer.sv
module ptest_pulse_timer #(
  parameter int STBY_IVL = 8,
  parameter int TEST_IVL = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic fast_i,
  output logic pulse_o
);

  localparam int MAX_IVL = (STBY_IVL > TEST_IVL) ? STBY_IVL : TEST_IVL;
  localparam int CW      = $clog2(MAX_IVL + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;
  logic          fast_q;
  logic          pulse_q;

  assign limit = fast_i ? CW'(TEST_IVL - 1) : CW'(STBY_IVL - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      fast_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      fast_q  <= fast_i;
      pulse_q <= 1'b0;
      if (fast_i != fast_q) begin
        cnt_q <= '0;                 // rate change restarts the interval
      end else if (tick_i) begin
        if (cnt_q >= limit) begin
          cnt_q   <= '0;
          pulse_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign pulse_o = pulse_q;

endmodule

// File: rtl/ptest_run_counter.sv
module ptest_run_counter #(
  parameter int PASS_RUN = 3,
  parameter int FAIL_RUN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic valid_i,
  input  logic smoke_i,
  output logic pass_o,
  output logic fail_o
);

  localparam int HW = $clog2(PASS_RUN + 1);
  localparam int MW = $clog2(FAIL_RUN + 1);

  logic [HW-1:0] hit_q;
  logic [MW-1:0] miss_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q  <= '0;
      miss_q <= '0;
    end else if (clr_i) begin
      hit_q  <= '0;
      miss_q <= '0;
    end else if (valid_i) begin
      if (smoke_i) begin
        miss_q <= '0;
        if (hit_q != HW'(PASS_RUN)) hit_q <= hit_q + 1'b1;
      end else begin
        hit_q <= '0;
        if (miss_q != MW'(FAIL_RUN)) miss_q <= miss_q + 1'b1;
      end
    end
  end

  assign pass_o = valid_i &  smoke_i & (hit_q  == HW'(PASS_RUN - 1));
  assign fail_o = valid_i & ~smoke_i & (miss_q == MW'(FAIL_RUN - 1));

endmodule

// File: rtl/ptest_seq.sv
module ptest_seq
  import ptest_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STBY_IVL    = 8,
  parameter int TEST_IVL    = 2,
  parameter int PASS_RUN    = 3,
  parameter int FAIL_RUN    = 3,
  parameter int EXIT_PULSES = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       osc_tick_i,
  input  logic       test_i,
  input  logic       hush_en_i,
  input  logic       smoke_valid_i,
  input  logic       smoke_i,
  output logic       gain_boost_o,
  output logic       ired_req_o,
  output logic [2:0] alarm_code_o,
  output logic       horn_en_o,
  output logic       io_en_o,
  output logic       hush_restart_o,
  output logic       latch_clear_o
);

  localparam int EW = $clog2(EXIT_PULSES + 1);

  seq_state_e    state_q, state_d;
  verdict_e      verdict_q, verdict_d;
  logic [EW-1:0] exit_q, exit_d;

  logic btn_lvl, btn_rise, btn_fall;
  logic res_valid, pass_hit, fail_hit;

  ptest_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (test_i),
    .level_o (btn_lvl),
    .rise_o  (btn_rise),
    .fall_o  (btn_fall)
  );

  ptest_pulse_timer #(.STBY_IVL(STBY_IVL), .TEST_IVL(TEST_IVL)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (osc_tick_i),
    .fast_i  (state_q != ST_IDLE),
    .pulse_o (ired_req_o)
  );

  assign res_valid = smoke_valid_i && (state_q == ST_HELD) && (verdict_q == VD_NONE);

  ptest_run_counter #(.PASS_RUN(PASS_RUN), .FAIL_RUN(FAIL_RUN)) u_runs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (btn_rise),
    .valid_i (res_valid),
    .smoke_i (smoke_i),
    .pass_o  (pass_hit),
    .fail_o  (fail_hit)
  );

  always_comb begin
    state_d   = state_q;
    verdict_d = verdict_q;
    exit_d    = exit_q;
    unique case (state_q)
      ST_IDLE: begin
        if (btn_rise) begin
          state_d   = ST_HELD;
          verdict_d = VD_NONE;
        end
      end
      ST_HELD: begin
        if (btn_fall) begin
          state_d = ST_REL_GAIN;
        end else if (verdict_q == VD_NONE) begin
          if (pass_hit)      verdict_d = VD_PASS;
          else if (fail_hit) verdict_d = VD_FAIL;
        end
      end
      ST_REL_GAIN: begin
        if (btn_rise) begin
          state_d   = ST_HELD;
          verdict_d = VD_NONE;
        end else if (osc_tick_i) begin
          state_d = ST_REL_CNT;
          exit_d  = '0;
        end
      end
      ST_REL_CNT: begin
        if (btn_rise) begin
          state_d   = ST_HELD;
          verdict_d = VD_NONE;
        end else if (ired_req_o) begin
          if (exit_q == EW'(EXIT_PULSES - 1)) begin
            state_d   = ST_IDLE;
            verdict_d = VD_NONE;
          end else begin
            exit_d = exit_q + 1'b1;
          end
        end
      end
      default: begin
        state_d   = ST_IDLE;
        verdict_d = VD_NONE;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      verdict_q <= VD_NONE;
      exit_q    <= '0;
    end else begin
      state_q   <= state_d;
      verdict_q <= verdict_d;
      exit_q    <= exit_d;
    end
  end

  always_comb begin
    unique case (verdict_q)
      VD_PASS: alarm_code_o = CODE_PASS;
      VD_FAIL: alarm_code_o = CODE_FAIL;
      default: alarm_code_o = CODE_NONE;
    endcase
  end

  assign gain_boost_o   = (state_q == ST_HELD) || (state_q == ST_REL_GAIN);
  assign horn_en_o      = (verdict_q == VD_PASS);
  assign io_en_o        = (verdict_q == VD_PASS);
  assign latch_clear_o  = btn_fall;
  assign hush_restart_o = btn_fall & hush_en_i;

  logic unused_lvl;
  assign unused_lvl = btn_lvl;

endmodule

// File: rtl/ptest_seq_chk.sv
module ptest_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       osc_tick_i,
  input logic       test_i,
  input logic       hush_en_i,
  input logic       gain_boost_o,
  input logic       ired_req_o,
  input logic [2:0] alarm_code_o,
  input logic       horn_en_o,
  input logic       io_en_o,
  input logic       hush_restart_o,
  input logic       latch_clear_o
);

  // R2
  gain_rise_needs_press_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gain_boost_o) |-> ($past(test_i, 3) && $past(test_i, 4)));

  // R4
  ired_after_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ired_req_o |-> $past(osc_tick_i));

  // R5
  horn_only_on_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    horn_en_o |-> (alarm_code_o == 3'b011 && io_en_o));

  // R6
  fail_is_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_code_o == 3'b100) |-> (!horn_en_o && !io_en_o));

  // R8
  gain_drop_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(gain_boost_o) |-> $past(osc_tick_i));

  // R9
  standby_after_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_code_o == 3'b000 && $past(alarm_code_o) != 3'b000 && !gain_boost_o)
      |-> $past(ired_req_o));

  // R10
  clear_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_clear_o |=> !latch_clear_o);

  // R11
  hush_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hush_restart_o |-> (latch_clear_o && hush_en_i));

  // R12
  pass_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_code_o == 3'b011) |=> (alarm_code_o == 3'b011 || alarm_code_o == 3'b000));

  // R12
  fail_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_code_o == 3'b100) |=> (alarm_code_o == 3'b100 || alarm_code_o == 3'b000));

endmodule

bind ptest_seq ptest_seq_chk u_chk (.*);

// File: tb/ptest_seq_tb.sv
module ptest_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int STBY       = 8;
  localparam int TEST       = 2;
  localparam int NRES       = 8;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       osc_tick_i = 1'b0;
  logic       test_i = 1'b0;
  logic       hush_en_i = 1'b0;
  logic       smoke_valid_i = 1'b0;
  logic       smoke_i = 1'b0;
  logic       gain_boost_o, ired_req_o, horn_en_o, io_en_o, hush_restart_o, latch_clear_o;
  logic [2:0] alarm_code_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int lc_cnt = 0;
  int hr_cnt = 0;
  int idx = NRES;
  logic [7:0] pat = '0;
  bit resp_pend = 1'b0;
  int tdiv = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptest_seq #(.STBY_IVL(STBY), .TEST_IVL(TEST)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .osc_tick_i(osc_tick_i), .test_i(test_i),
    .hush_en_i(hush_en_i), .smoke_valid_i(smoke_valid_i), .smoke_i(smoke_i),
    .gain_boost_o(gain_boost_o), .ired_req_o(ired_req_o), .alarm_code_o(alarm_code_o),
    .horn_en_o(horn_en_o), .io_en_o(io_en_o), .hush_restart_o(hush_restart_o),
    .latch_clear_o(latch_clear_o)
  );

  always @(posedge clk) cyc++;

  // oscillator tick, nonblocking so negedge readers see the value the DUT just sampled
  always @(negedge clk) begin
    tdiv = (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
    osc_tick_i <= (tdiv == 0);
  end

  always @(negedge clk) begin
    if (latch_clear_o)  lc_cnt++;
    if (hush_restart_o) hr_cnt++;
  end

  // comparator model: answers test-mode pulses with the next pattern bit
  always @(negedge clk) begin
    if (resp_pend) begin
      smoke_valid_i <= 1'b1;
      smoke_i       <= pat[idx];
      idx           <= idx + 1;
      resp_pend     <= 1'b0;
    end else begin
      smoke_valid_i <= 1'b0;
    end
    if (ired_req_o && gain_boost_o && idx < NRES && !resp_pend) resp_pend <= 1'b1;
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [2:0] predict(input logic [7:0] p);
    int h = 0;
    int m = 0;
    for (int i = 0; i < NRES; i++) begin
      if (p[i]) begin
        h++; m = 0;
        if (h == 3) return 3'b011;
      end else begin
        m++; h = 0;
        if (m == 3) return 3'b100;
      end
    end
    return 3'b000;
  endfunction

  task automatic wait_ired(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (ired_req_o) begin ok = 1'b1; break; end
    end
  endtask

  task automatic run_test(input logic [7:0] p, input bit hush, input string tag);
    logic [2:0] exp;
    int t0, lc0, hr0, tk, np;
    bit ok;
    exp = predict(p);
    @(negedge clk);
    hush_en_i = hush;
    pat = p;
    idx = 0;
    test_i = 1'b1;
    for (int i = 0; i < 20 && !gain_boost_o; i++) @(negedge clk);
    // R3 gain on while held
    chk(gain_boost_o, "R3 gain boost while held", gain_boost_o, 1);
    // R4 test interval
    wait_ired(ok); t0 = cyc;
    wait_ired(ok);
    chk(ok && (cyc - t0) == TEST * TICK_DIV, "R4 test pulse interval", cyc - t0, TEST * TICK_DIV);
    for (int i = 0; i < 2000 && idx < NRES; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(alarm_code_o == exp, tag, alarm_code_o, exp);
    chk(horn_en_o == (exp == 3'b011) && io_en_o == (exp == 3'b011),
        "R5 R6 horn/interconnect follow verdict", {horn_en_o, io_en_o}, (exp == 3'b011) ? 3 : 0);
    chk(gain_boost_o, "R3 gain boost still held", gain_boost_o, 1);
    // release
    lc0 = lc_cnt; hr0 = hr_cnt;
    test_i = 1'b0;
    for (int i = 0; i < 20 && !latch_clear_o; i++) @(negedge clk);
    @(negedge clk);
    chk(gain_boost_o, "R8 gain held until tick", gain_boost_o, 1);
    tk = 0;
    for (int i = 0; i < 4 * TICK_DIV; i++) begin
      @(negedge clk);
      if (osc_tick_i) tk++;
      if (!gain_boost_o) break;
    end
    chk(!gain_boost_o && tk == 1, "R8 gain drop on first tick", tk, 1);
    chk(alarm_code_o == exp, "R9 verdict kept after gain drop", alarm_code_o, exp);
    np = 0;
    for (int i = 0; i < 400; i++) begin
      if (ired_req_o) np++;
      if (np == 3) break;
      @(negedge clk);
    end
    chk(np == 3 && alarm_code_o == exp, "R9 verdict kept to last exit pulse", alarm_code_o, exp);
    @(negedge clk);
    chk(alarm_code_o == 3'b000 && !horn_en_o && !io_en_o, "R9 standby after exit pulses",
        alarm_code_o, 0);
    repeat (2) @(negedge clk);
    chk(lc_cnt - lc0 == 1, "R10 one latch clear per release", lc_cnt - lc0, 1);
    chk(hr_cnt - hr0 == int'(hush), "R11 hush restart gated", hr_cnt - hr0, int'(hush));
    repeat (5) @(negedge clk);
  endtask

  initial begin
    int t0, bad;
    bit ok;
    void'($urandom(32'h1d5e_7001));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1
    chk(!gain_boost_o && !horn_en_o && !io_en_o && !hush_restart_o && !latch_clear_o
        && alarm_code_o == 3'b000, "R1 reset state", alarm_code_o, 0);
    // R4 standby interval
    wait_ired(ok); t0 = cyc;
    wait_ired(ok);
    chk(ok && (cyc - t0) == STBY * TICK_DIV, "R4 standby pulse interval", cyc - t0, STBY * TICK_DIV);
    // R2 glitch
    @(negedge clk);
    test_i = 1'b1;
    @(negedge clk);
    test_i = 1'b0;
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (gain_boost_o || latch_clear_o) bad++;
    end
    chk(bad == 0, "R2 one-cycle glitch ignored", bad, 0);
    // directed patterns, bit k = result k
    run_test(8'h07, 1'b1, "R5 three smoke results pass");
    run_test(8'h00, 1'b0, "R6 three misses fail");
    run_test(8'h24, 1'b1, "R7 interleaved misses no verdict");
    run_test(8'hDB, 1'b0, "R7 interleaved hits no verdict");
    run_test(8'hF8, 1'b1, "R12 fail sticky against later hits");
    run_test(8'hC7, 1'b0, "R12 pass sticky against later misses");
    for (int n = 0; n < 10; n++) begin
      run_test(8'($urandom), 1'($urandom), "R5 R6 R7 random pattern verdict");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule